// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control core of a small stored-program processor with 16-bit words. It walks each instruction through six phases: fetch, decode, address evaluation, operand fetch, execute and result store. Along the way it drives the program counter, the instruction register, the memory address register (MAR) and the memory data register (MDR). Memory is reached through a single port with a request, a write enable and a ready flag, so any memory access can take a variable number of clocks.

After decode, the block sorts each instruction into one of three classes: operate, data movement or control. It then skips the phases that the class does not use. The block includes a small register file and ALU so that each class has a visible effect. The current phase is brought out so the sequence can be observed.

Top module: `instr_seq`

## Requirements
- R1: `phase_o` reports the current phase with these codes: fetch=0, decode=1, address evaluation=2, operand fetch=3, execute=4, store=5. Every visited phase appears in ascending order, and after the last phase of an instruction the next clock returns to fetch.
- R2: Fetch runs four micro-steps in order: MAR takes PC (1 clock), PC increments by one (1 clock), memory is read into MDR (1 + W clocks, where W is the number of clocks ready stays low), and IR takes MDR (1 clock). Fetch therefore lasts W+4 clocks.
- R3: A read holds `mem_req_o` high with `mem_we_o` low and keeps the address stable until `mem_rdy_i` is high. In the clock where ready is high, MDR captures `mem_rdata_i`.
- R4: A memory write first loads MDR during operand fetch. It then raises `mem_we_o` with `mem_req_o` in the store phase and holds both, with MAR and MDR stable, until ready. The MDR value is stored at the MAR address.
- R5: The class is decoded from IR[15:12]. Opcodes 2 and 3 are data movement, opcodes 0 and 12 are control, and every other opcode is operate.
- R6: Operate instructions skip address evaluation. Their phase order is 0,1,3,4,5 and they take W+8 clocks. Opcode 1 adds, 5 ANDs, 9 inverts the first source, and any other operate opcode copies the first source. The result is written to the register IR[11:9], with sources IR[8:6] and IR[2:0].
- R7: Data movement skips execute. Its phase order is 0,1,2,3,5 and it takes 2W+8 clocks. The address is the incremented PC plus IR[8:0] sign-extended. Opcode 2 loads memory into register IR[11:9]; opcode 3 stores register IR[11:9] to memory.
- R8: Control instructions skip operand fetch and store. Their phase order is 0,1,2,4 and they take W+7 clocks. In execute, PC is set to the target, and the next fetch uses that target. Opcode 0 jumps to the incremented PC plus IR[8:0] sign-extended; opcode 12 jumps to the register IR[8:6].
- R9: Reset (`rst_ni` low) clears PC and all registers and enters the first fetch micro-step. While reset is held, `mem_we_o` and `rf_we_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_rdy_i | input | 1 | Memory access completes this clock |
| mem_rdata_i | input | 16 | Read data for the MAR address |
| mem_req_o | output | 1 | Memory access in progress |
| mem_we_o | output | 1 | Access is a write of MDR |
| mem_addr_o | output | 16 | MAR contents |
| mem_wdata_o | output | 16 | MDR contents |
| phase_o | output | 3 | Current phase code |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| rf_we_o | output | 1 | Register write this clock |
| rf_waddr_o | output | 3 | Register being written |
| rf_wdata_o | output | 16 | Value being written |

## Verification
The bench runs a fixed program that reaches every class and several operate opcodes. It repeats the program with the memory ready delay W swept from 0 to 3 clocks. Each instruction's phase trace is sampled on the falling edge of every clock and checked against the expected clock count: W+8 for operate, 2W+8 for data movement, W+7 for control. A register write is due in the single store clock and is checked there. The program counter is read in the first fetch clock of the following instruction, which checks the branch target. Stored memory words are read back after the store phase has ended.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    PH_FETCH = 3'd0, PH_DEC = 3'd1, PH_EA = 3'd2,
    PH_OPND  = 3'd3, PH_EXEC = 3'd4, PH_STORE = 3'd5
  } phase_e;

  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_INC, ST_F_RD, ST_F_IR,
    ST_DEC, ST_EA, ST_OPND, ST_EXEC, ST_STORE
  } step_e;

  typedef enum logic [1:0] {CL_OPER, CL_MOVE, CL_CTRL} cls_e;

  localparam logic [3:0] OP_BRA = 4'h0;
  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_LD  = 4'h2;
  localparam logic [3:0] OP_ST  = 4'h3;
  localparam logic [3:0] OP_AND = 4'h5;
  localparam logic [3:0] OP_NOT = 4'h9;
  localparam logic [3:0] OP_JMP = 4'hC;

  function automatic phase_e step_phase(step_e s);
    case (s)
      ST_DEC:   return PH_DEC;
      ST_EA:    return PH_EA;
      ST_OPND:  return PH_OPND;
      ST_EXEC:  return PH_EXEC;
      ST_STORE: return PH_STORE;
      default:  return PH_FETCH;
    endcase
  endfunction

  function automatic cls_e op_class(logic [3:0] op);
    case (op)
      OP_LD, OP_ST:   return CL_MOVE;
      OP_BRA, OP_JMP: return CL_CTRL;
      default:        return CL_OPER;
    endcase
  endfunction
endpackage

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_NOT:  y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RAW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RAW-1:0] raddr_a_i,
  input  logic [RAW-1:0] raddr_b_i,
  output logic [DW-1:0]  rdata_a_o,
  output logic [DW-1:0]  rdata_b_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && waddr_i == RAW'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rdy_i,
  input  cls_e  cls_i,
  input  logic  is_ld_i,
  output step_e step_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_F_MAR: step_d = ST_F_INC;
      ST_F_INC: step_d = ST_F_RD;
      ST_F_RD:  if (rdy_i) step_d = ST_F_IR;
      ST_F_IR:  step_d = ST_DEC;
      ST_DEC:   step_d = (cls_i == CL_OPER) ? ST_OPND : ST_EA;
      ST_EA:    step_d = (cls_i == CL_MOVE) ? ST_OPND : ST_EXEC;
      ST_OPND: begin
        if (cls_i == CL_OPER)  step_d = ST_EXEC;
        else if (!is_ld_i)     step_d = ST_STORE;
        else if (rdy_i)        step_d = ST_STORE;
      end
      ST_EXEC:  step_d = (cls_i == CL_CTRL) ? ST_F_MAR : ST_STORE;
      ST_STORE: begin
        if (cls_i != CL_MOVE || is_ld_i || rdy_i) step_d = ST_F_MAR;
      end
      default:  step_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_F_MAR;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  // phase skipping per class
  assert_oper_skip_ea_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_DEC && cls_i == CL_OPER) |=> step_q == ST_OPND);
  assert_move_skip_ex_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_OPND && cls_i == CL_MOVE) |=> step_q != ST_EXEC);
  assert_ctrl_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_EXEC && cls_i == CL_CTRL) |=> step_q == ST_F_MAR);
endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mem_rdy_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic [2:0]     phase_o,
  output logic [DW-1:0]  pc_o,
  output logic [DW-1:0]  ir_o,
  output logic           rf_we_o,
  output logic [RAW-1:0] rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o
);
  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, ea_q, opa_q, opb_q, res_q;
  logic [DW-1:0] rf_a, rf_b, alu_y, rel_tgt;
  logic [3:0]    opc;
  logic [RAW-1:0] f_rd, f_ra, f_rb;
  cls_e  cls;
  step_e step;
  logic  is_ld, is_st, mdr_ld;

  assign opc     = ir_q[15:12];
  assign f_rd    = ir_q[9+RAW-1:9];
  assign f_ra    = ir_q[6+RAW-1:6];
  assign f_rb    = is_st ? f_rd : ir_q[RAW-1:0];
  assign cls     = op_class(opc);
  assign is_ld   = (opc == OP_LD);
  assign is_st   = (opc == OP_ST);
  assign rel_tgt = pc_q + {{(DW-9){ir_q[8]}}, ir_q[8:0]};

  seq_fsm u_fsm (
    .clk_i, .rst_ni, .rdy_i(mem_rdy_i), .cls_i(cls), .is_ld_i(is_ld), .step_o(step)
  );

  seq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni, .we_i(rf_we_o), .waddr_i(rf_waddr_o), .wdata_i(rf_wdata_o),
    .raddr_a_i(f_ra), .raddr_b_i(f_rb), .rdata_a_o(rf_a), .rdata_b_o(rf_b)
  );

  seq_alu #(.DW(DW)) u_alu (.op_i(opc), .a_i(opa_q), .b_i(opb_q), .y_o(alu_y));

  assign mdr_ld = (step == ST_F_RD && mem_rdy_i) ||
                  (step == ST_OPND && cls == CL_MOVE && (!is_ld || mem_rdy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; ir_q <= '0; mar_q <= '0; mdr_q <= '0;
      ea_q <= '0; opa_q <= '0; opb_q <= '0; res_q <= '0;
    end else begin
      case (step)
        ST_F_MAR: mar_q <= pc_q;
        ST_F_INC: pc_q  <= pc_q + 1'b1;
        ST_F_RD:  if (mem_rdy_i) mdr_q <= mem_rdata_i;
        ST_F_IR:  ir_q  <= mdr_q;
        ST_EA: begin
          ea_q <= (opc == OP_JMP) ? rf_a : rel_tgt;
          if (cls == CL_MOVE) mar_q <= rel_tgt;
        end
        ST_OPND: begin
          if (cls == CL_OPER) begin
            opa_q <= rf_a;
            opb_q <= rf_b;
          end else if (is_ld) begin
            if (mem_rdy_i) mdr_q <= mem_rdata_i;
          end else begin
            mdr_q <= rf_b;
          end
        end
        ST_EXEC: begin
          if (cls == CL_OPER) res_q <= alu_y;
          else                pc_q  <= ea_q;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (step == ST_F_RD) || (step == ST_OPND && is_ld) ||
                       (step == ST_STORE && is_st);
  assign mem_we_o    = (step == ST_STORE) && is_st;
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign phase_o     = step_phase(step);
  assign pc_o        = pc_q;
  assign ir_o        = ir_q;
  assign rf_we_o     = (step == ST_STORE) && (cls == CL_OPER || is_ld);
  assign rf_waddr_o  = f_rd;
  assign rf_wdata_o  = (cls == CL_OPER) ? res_q : mdr_q;

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == ST_F_INC) |=> pc_q == $past(pc_q) + 1'b1);
  assert_ir_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == ST_F_IR) |=> ir_q == $past(mdr_q));
  assert_read_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && !mem_rdy_i) |=> mem_req_o && !mem_we_o && $stable(mar_q));
  assert_mdr_before_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mdr_ld));
  assert_write_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_rdy_i) |=> mem_we_o && $stable(mdr_q) && $stable(mar_q));
  assert_we_store_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (phase_o == PH_STORE) && mem_req_o);
endmodule

// File: tb/sim_instr_seq.sv
module sim_instr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_rdy_i;
  logic [15:0] mem_rdata_i;
  logic        mem_req_o, mem_we_o, rf_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, pc_o, ir_o, rf_wdata_o;
  logic [2:0]  phase_o, rf_waddr_o;

  int n_chk = 0, n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  logic [15:0] mem [256];

  always #4 clk_i = ~clk_i;

  instr_seq u0 (.*);

  assign mem_rdy_i   = mem_req_o && (wcnt == lat);
  assign mem_rdata_i = mem[mem_addr_o[7:0]];

  always @(posedge clk_i) begin
    if (!rst_ni) wcnt <= 0;
    else if (mem_req_o && !mem_rdy_i) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (rst_ni && mem_req_o && mem_we_o && mem_rdy_i) mem[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h223F; // LD R1 <- [0x40]
    mem[1]  = 16'h243F; // LD R2 <- [0x41]
    mem[2]  = 16'h1642; // ADD R3 = R1+R2
    mem[3]  = 16'h5842; // AND R4 = R1&R2
    mem[4]  = 16'h9A40; // NOT R5 = ~R1
    mem[5]  = 16'h363C; // ST R3 -> [0x42]
    mem[6]  = 16'h0003; // BRA -> 10
    mem[7]  = 16'h1C42; // skipped
    mem[8]  = 16'h1C42;
    mem[9]  = 16'h1C42;
    mem[10] = 16'h2E38; // LD R7 <- [0x43]
    mem[11] = 16'hC1C0; // JMP R7 -> 20
    mem[20] = 16'h01F7; // BRA -9 -> 12
    mem[12] = 16'h1CC3; // ADD R6 = R3+R3
    mem[13] = 16'hF140; // copy R0 = R5
    mem[14] = 16'h0FFF; // BRA to self
    mem[16'h40] = 16'h1234;
    mem[16'h41] = 16'h0F0F;
    mem[16'h43] = 16'h0014;
  endtask

  // runs one instruction, starting in its first fetch clock (at a falling edge)
  task automatic run_one(input string req, input logic [31:0] exp_seq, input int exp_len,
                         input logic [15:0] exp_pc, input int exp_wr,
                         input logic [2:0] exp_wa, input logic [15:0] exp_wd);
    logic [31:0] seq = 0;
    logic [2:0]  prev = 3'd7;
    int cyc = 0, wr_n = 0;
    logic [2:0]  wa = 0;
    logic [15:0] wd = 0;
    do begin
      if (phase_o != prev) seq = (seq << 4) | {29'd0, phase_o};
      prev = phase_o;
      if (rf_we_o) begin wr_n++; wa = rf_waddr_o; wd = rf_wdata_o; end
      cyc++;
      @(negedge clk_i);
    end while (!(phase_o == 3'd0 && prev != 3'd0) && cyc < 100);
    check(seq == exp_seq, {req, " R1"}, "phase order", seq, exp_seq);
    check(cyc == exp_len, {req, " R2 R3"}, "cycle count", cyc, exp_len);
    check(pc_o == exp_pc, {req, " R8"}, "next pc", pc_o, exp_pc);
    check(wr_n == exp_wr, req, "reg writes", wr_n, exp_wr);
    if (exp_wr != 0) begin
      check(wa == exp_wa, req, "write reg", wa, exp_wa);
      check(wd == exp_wd, req, "write data", wd, exp_wd);
    end
  endtask

  localparam logic [31:0] SQ_OPER = 32'h01345;
  localparam logic [31:0] SQ_MOVE = 32'h01235;
  localparam logic [31:0] SQ_CTRL = 32'h0124;

  initial begin
    for (int l = 0; l < 4; l++) begin
      rst_ni = 1'b0;
      lat = l;
      load_prog();
      repeat (3) @(negedge clk_i);
      // R9 reset state
      check(pc_o == 0, "R9", "pc in reset", pc_o, 0);
      check(phase_o == 0, "R9", "phase in reset", phase_o, 0);
      check(!mem_we_o && !rf_we_o, "R9", "write enables in reset", {mem_we_o, rf_we_o}, 0);
      rst_ni = 1'b1;
      run_one("R7 R5 ld", SQ_MOVE, 2*l+8, 16'd1,  1, 3'd1, 16'h1234);
      run_one("R7 ld",    SQ_MOVE, 2*l+8, 16'd2,  1, 3'd2, 16'h0F0F);
      run_one("R6 add",   SQ_OPER, l+8,   16'd3,  1, 3'd3, 16'h2143);
      run_one("R6 and",   SQ_OPER, l+8,   16'd4,  1, 3'd4, 16'h0204);
      run_one("R6 not",   SQ_OPER, l+8,   16'd5,  1, 3'd5, 16'hEDCB);
      run_one("R7 R4 st", SQ_MOVE, 2*l+8, 16'd6,  0, 3'd0, 16'h0);
      check(mem[16'h42] == 16'h2143, "R4", "stored word", mem[16'h42], 16'h2143);
      run_one("R8 bra",   SQ_CTRL, l+7,   16'd10, 0, 3'd0, 16'h0);
      run_one("R7 ld",    SQ_MOVE, 2*l+8, 16'd11, 1, 3'd7, 16'h0014);
      run_one("R8 jmp",   SQ_CTRL, l+7,   16'd20, 0, 3'd0, 16'h0);
      run_one("R8 bra back", SQ_CTRL, l+7, 16'd12, 0, 3'd0, 16'h0);
      run_one("R6 add2",  SQ_OPER, l+8,   16'd13, 1, 3'd6, 16'h4286);
      run_one("R6 R5 copy", SQ_OPER, l+8, 16'd14, 1, 3'd0, 16'hEDCB);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule